// File: doc/BRIEF.md
# Superpage-Capable Translation Buffer

This block is a fully associative address translation buffer. Each slot holds one mapping from a virtual page number to a physical page number. A slot maps either a single 8 KB base page or a 128 KB superpage. A superpage is an aligned run of 16 contiguous base pages, with an equally aligned run of 16 contiguous physical frames behind it. A per-slot size flag controls the tag compare. For a superpage slot, the low four bits of the virtual page number are left out of the compare and passed straight through into the translated frame number.

A lookup strobe with a virtual page number returns hit and the physical page number one clock later. An insert port writes a new mapping. Before the write, every resident mapping whose page range overlaps the new one is dropped. As a result, a promoted superpage removes its base pages, and a base page written inside a superpage demotes that superpage. A round-robin pointer picks the slot to write, and it moves ahead to the first free slot when one exists. A flush command clears every mapping at once.

Top module: `tlb_sp`

## Requirements
- R1: After reset no slot is valid, so every lookup misses. rsp_valid is high exactly in the cycle after a cycle with lk_req high, and low otherwise.
- R2: A base-page slot hits only when the lookup number equals its stored virtual page number in all bits. rsp_ppn then equals the stored physical page number.
- R3: A superpage slot hits whenever the lookup number agrees with its stored number in all bits above bit 3. rsp_ppn takes bits above 3 from the stored frame number and bits 3..0 from the lookup number.
- R4: A superpage insert whose virtual or physical number has any of bits 3..0 set raises ins_err for one cycle, in the cycle after the insert, and changes no slot.
- R5: An accepted insert invalidates every valid slot whose range overlaps the new range. Two ranges overlap when bits above 3 are equal and either slot is a superpage or the full numbers are equal.
- R6: At most one slot matches any lookup.
- R7: An accepted insert writes the first slot, counting upward from the pointer and wrapping, that is invalid or being invalidated by R5. If no such slot exists, it writes the slot at the pointer. The pointer then moves to the slot after the one written, wrapping at the last slot.
- R8: flush invalidates every slot and leaves the pointer unchanged. An insert in the same cycle as flush is ignored and raises no error.
- R9: A lookup issued in the same cycle as an insert or flush sees the slot contents from before that cycle.
- R10: On a miss, rsp_ppn is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup strobe |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| ins_req | input | 1 | Insert strobe |
| ins_vpn | input | VPN_W | Virtual page number of the new mapping |
| ins_ppn | input | PPN_W | Physical page number of the new mapping |
| ins_super | input | 1 | New mapping is a 16-page superpage |
| flush | input | 1 | Invalidate all slots |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup matched a slot |
| rsp_ppn | output | PPN_W | Translated physical page number |
| ins_err | output | 1 | Misaligned superpage insert rejected |

## Verification
The single-match check depends on every mapping entering through the insert port, where overlaps are removed. The bench therefore never forces slot state and always follows an insert with its lookups. The pass-through check assumes lk_vpn is held steady for the cycle it is sampled, and the bench drives each input once per cycle at the falling edge. The superpage stimulus covers aligned and misaligned bases in both the virtual and the physical number, demotion by a base insert, and promotion over resident base pages. All of it stays inside those driving rules.

// File: rtl/tlb_sp_pkg.sv
package tlb_sp_pkg;
  localparam int SP_SHIFT    = 4;
  localparam int DEF_ENTRIES = 128;
  localparam int DEF_VPN_W   = 19;
  localparam int DEF_PPN_W   = 18;
endpackage

// File: rtl/tlb_sp_entries.sv
module tlb_sp_entries #(
  parameter int N     = 128,
  parameter int VPN_W = 19,
  parameter int PPN_W = 18,
  parameter int SPB   = 4,
  parameter int IW    = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_sup,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic [N-1:0]     hit_v,
  output logic [N-1:0]     ovl_v,
  output logic [N-1:0]     vld_v,
  output logic             sup_hit,
  output logic [PPN_W-1:0] rd_ppn
);
  logic [VPN_W-1:0] tag_q [N];
  logic [PPN_W-1:0] frm_q [N];
  logic [N-1:0]     sup_q;

  function automatic logic [PPN_W-1:0] xlate(input logic [PPN_W-1:0] frm,
                                             input logic [VPN_W-1:0] va,
                                             input logic sup);
    logic [PPN_W-1:0] r;
    r = frm;
    if (sup) r[SPB-1:0] = va[SPB-1:0];
    return r;
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic hi_eq_lk, lo_eq_lk, hi_eq_wr, lo_eq_wr;
    assign hi_eq_lk = tag_q[i][VPN_W-1:SPB] == lk_vpn[VPN_W-1:SPB];
    assign lo_eq_lk = tag_q[i][SPB-1:0] == lk_vpn[SPB-1:0];
    assign hi_eq_wr = tag_q[i][VPN_W-1:SPB] == wr_vpn[VPN_W-1:SPB];
    assign lo_eq_wr = tag_q[i][SPB-1:0] == wr_vpn[SPB-1:0];
    assign hit_v[i] = vld_v[i] && hi_eq_lk && (sup_q[i] || lo_eq_lk);
    assign ovl_v[i] = vld_v[i] && hi_eq_wr && (sup_q[i] || wr_sup || lo_eq_wr);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_v[i] <= 1'b0;
        sup_q[i] <= 1'b0;
        tag_q[i] <= '0;
        frm_q[i] <= '0;
      end else if (clr_all) begin
        vld_v[i] <= 1'b0;
      end else if (wr_en && wr_idx == IW'(i)) begin
        vld_v[i] <= 1'b1;
        sup_q[i] <= wr_sup;
        tag_q[i] <= wr_vpn;
        frm_q[i] <= wr_ppn;
      end else if (wr_en && ovl_v[i]) begin
        vld_v[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_ppn  = '0;
    sup_hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hit_v[i]) begin
        rd_ppn  = rd_ppn | xlate(frm_q[i], lk_vpn, sup_q[i]);
        sup_hit = sup_hit | sup_q[i];
      end
    end
  end

  assert_one_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_v));
endmodule

// File: rtl/tlb_sp_victim.sv
module tlb_sp_victim #(
  parameter int N  = 128,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  free_v,
  input  logic [IW-1:0] ptr,
  output logic [IW-1:0] victim
);
  always_comb begin
    logic found;
    logic [IW:0] cand;
    victim = ptr;
    found  = 1'b0;
    for (int k = 0; k < N; k++) begin
      cand = {1'b0, ptr} + (IW+1)'(k);
      if (cand >= (IW+1)'(N)) cand = cand - (IW+1)'(N);
      if (!found && free_v[cand[IW-1:0]]) begin
        victim = cand[IW-1:0];
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_sp.sv
module tlb_sp import tlb_sp_pkg::*; #(
  parameter int N     = DEF_ENTRIES,
  parameter int VPN_W = DEF_VPN_W,
  parameter int PPN_W = DEF_PPN_W,
  parameter int SPB   = SP_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             ins_req,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic             ins_super,
  input  logic             flush,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             ins_err
);
  localparam int IW = $clog2(N);

  function automatic logic base_misaligned(input logic [VPN_W-1:0] va,
                                           input logic [PPN_W-1:0] pa);
    return (|va[SPB-1:0]) || (|pa[SPB-1:0]);
  endfunction

  function automatic logic [IW-1:0] next_slot(input logic [IW-1:0] s);
    return (s == IW'(N-1)) ? '0 : s + 1'b1;
  endfunction

  logic [N-1:0]     hit_v, ovl_v, vld_v, free_v;
  logic             sup_hit, ins_bad, wr_en, any_vld;
  logic [PPN_W-1:0] rd_ppn;
  logic [IW-1:0]    ptr_q, victim;

  assign ins_bad = ins_req && !flush && ins_super && base_misaligned(ins_vpn, ins_ppn);
  assign wr_en   = ins_req && !flush && !ins_bad;
  assign free_v  = ~vld_v | ovl_v;
  assign any_vld = |vld_v;

  tlb_sp_entries #(.N(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .SPB(SPB), .IW(IW)) u_ent (
    .clk(clk), .rst_n(rst_n), .clr_all(flush), .wr_en(wr_en), .wr_idx(victim),
    .wr_vpn(ins_vpn), .wr_ppn(ins_ppn), .wr_sup(ins_super), .lk_vpn(lk_vpn),
    .hit_v(hit_v), .ovl_v(ovl_v), .vld_v(vld_v), .sup_hit(sup_hit), .rd_ppn(rd_ppn));

  tlb_sp_victim #(.N(N), .IW(IW)) u_vic (.free_v(free_v), .ptr(ptr_q), .victim(victim));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      ins_err   <= 1'b0;
    end else begin
      if (wr_en) ptr_q <= next_slot(victim);
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req && (|hit_v);
      rsp_ppn   <= lk_req ? rd_ppn : '0;
      ins_err   <= ins_bad;
    end
  end

  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);
  assert_rsp_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);
  assert_pass_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && sup_hit) |=> rsp_ppn[SPB-1:0] == $past(lk_vpn[SPB-1:0]));
  assert_reject_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_bad |=> ins_err);
  assert_victim_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (|free_v)) |-> free_v[victim]);
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !any_vld);
  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_ppn == '0);
endmodule

// File: tb/sim_tlb_sp.sv
`timescale 1ns/1ps
module sim_tlb_sp;
  localparam int N = 128;
  localparam int VW = 19;
  localparam int PW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_req = 1'b0, ins_req = 1'b0, ins_super = 1'b0, flush = 1'b0;
  logic [VW-1:0] lk_vpn = '0, ins_vpn = '0;
  logic [PW-1:0] ins_ppn = '0;
  logic rsp_valid, rsp_hit, ins_err;
  logic [PW-1:0] rsp_ppn;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  tlb_sp u0 (.clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
    .ins_req(ins_req), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_super(ins_super),
    .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .ins_err(ins_err));

  typedef struct {
    logic          hit;
    logic [PW-1:0] ppn;
    string         tag;
  } exp_t;
  exp_t sb[$];

  logic          m_vld [N];
  logic [VW-1:0] m_vpn [N];
  logic [PW-1:0] m_ppn [N];
  logic          m_sup [N];
  int            m_ptr;

  function automatic exp_t predict(input logic [VW-1:0] v, input string tag);
    exp_t e;
    e.hit = 1'b0; e.ppn = '0; e.tag = tag;
    for (int i = 0; i < N; i++)
      if (m_vld[i] && (m_vpn[i] >> 4) == (v >> 4) && (m_sup[i] || m_vpn[i] == v)) begin
        e.hit = 1'b1;
        e.ppn = m_sup[i] ? {m_ppn[i][PW-1:4], v[3:0]} : m_ppn[i];
      end
    return e;
  endfunction

  function automatic logic model_insert(input logic [VW-1:0] v, input logic [PW-1:0] p,
                                        input logic s);
    logic ov [N];
    int slot;
    if (s && (v[3:0] != 0 || p[3:0] != 0)) return 1'b1;
    for (int i = 0; i < N; i++)
      ov[i] = m_vld[i] && (m_vpn[i] >> 4) == (v >> 4) && (m_sup[i] || s || m_vpn[i] == v);
    slot = m_ptr;
    for (int k = N - 1; k >= 0; k--)
      if (!m_vld[(m_ptr + k) % N] || ov[(m_ptr + k) % N]) slot = (m_ptr + k) % N;
    for (int i = 0; i < N; i++) if (ov[i]) m_vld[i] = 1'b0;
    m_vld[slot] = 1'b1; m_vpn[slot] = v; m_ppn[slot] = p; m_sup[slot] = s;
    m_ptr = (slot + 1) % N;
    return 1'b0;
  endfunction

  // One cycle of stimulus; results are sampled at the following falling edge.
  task automatic step(input logic lk, input logic [VW-1:0] lv,
                      input logic in, input logic [VW-1:0] iv, input logic [PW-1:0] ip,
                      input logic is, input logic fl, input string tag);
    logic experr;
    experr = 1'b0;
    @(negedge clk);
    lk_req = lk; lk_vpn = lv; ins_req = in; ins_vpn = iv; ins_ppn = ip;
    ins_super = is; flush = fl;
    if (lk) sb.push_back(predict(lv, tag));
    if (fl) begin
      for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    end else if (in) experr = model_insert(iv, ip, is);
    @(negedge clk);
    lk_req = 1'b0; ins_req = 1'b0; flush = 1'b0; ins_super = 1'b0;
    if (in) begin
      checks++;
      if (ins_err !== experr) begin
        fails++;
        $display("FAIL %s ins_err actual=%0b expected=%0b", tag, ins_err, experr);
      end
    end
  endtask

  task automatic look(input logic [VW-1:0] v, input string tag);
    step(1'b1, v, 1'b0, '0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic ins(input logic [VW-1:0] v, input logic [PW-1:0] p, input logic s,
                     input string tag);
    step(1'b0, '0, 1'b1, v, p, s, 1'b0, tag);
  endtask

  // Monitor: compare every response against the oldest queued expectation.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected response actual=1 expected=0");
      end else begin
        e = sb.pop_front();
        if (rsp_hit !== e.hit || rsp_ppn !== e.ppn) begin
          fails++;
          $display("FAIL %s actual hit=%0b ppn=%h expected hit=%0b ppn=%h",
                   e.tag, rsp_hit, rsp_ppn, e.hit, e.ppn);
        end
      end
    end
  end

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0; m_sup[i] = 1'b0;
    end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || ins_err !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual=%0b%0b expected=00", rsp_valid, ins_err);
    end
    rst_n = 1'b1;

    look(19'h00000, "R1 empty lookup");
    ins(19'h00100, 18'h0003A, 1'b0, "R2 base insert");
    look(19'h00100, "R2 base hit");
    look(19'h00101, "R10 base neighbour miss");

    ins(19'h00040, 18'h00200, 1'b1, "R3 superpage insert");
    for (int k = 0; k < 16; k++) look(19'h00040 + VW'(k), "R3 superpage covered page");
    look(19'h0003F, "R3 below range");
    look(19'h00050, "R3 above range");

    ins(19'h00041, 18'h00300, 1'b1, "R4 misaligned virtual base");
    ins(19'h00060, 18'h00305, 1'b1, "R4 misaligned physical base");
    look(19'h00041, "R4 old mapping unchanged");
    look(19'h00060, "R4 nothing written");

    for (int k = 0; k < 4; k++)
      ins(19'h00300 + VW'(k), 18'h01000 + PW'(k), 1'b0, "R5 base pages");
    ins(19'h00300, 18'h02000, 1'b1, "R5 promote");
    look(19'h00302, "R5 promoted superpage");
    look(19'h0030F, "R6 single match");
    ins(19'h00305, 18'h00777, 1'b0, "R5 demote");
    look(19'h00305, "R5 new base page");
    look(19'h00306, "R5 demoted superpage gone");

    step(1'b1, 19'h00100, 1'b1, 19'h00100, 18'h00055, 1'b0, 1'b0, "R9 lookup sees old");
    look(19'h00100, "R9 new mapping after");

    step(1'b1, 19'h00100, 1'b1, 19'h00400, 18'h00001, 1'b0, 1'b1, "R8 flush with insert");
    look(19'h00100, "R8 flushed");
    look(19'h00400, "R8 insert ignored");

    for (int k = 0; k < N; k++) ins(19'h01000 + VW'(k), PW'(k + 1), 1'b0, "R7 fill");
    ins(19'h02000, 18'h00AAA, 1'b0, "R7 evict at pointer");
    look(19'h01000, "R7 oldest evicted");
    look(19'h01001, "R7 second kept");
    look(19'h02000, "R7 new entry");
    ins(19'h01010, 18'h03000, 1'b1, "R7 free slots by promotion");
    ins(19'h03000, 18'h00BBB, 1'b0, "R7 skip to free slot");
    look(19'h01001, "R7 pointer slot not evicted");
    look(19'h03000, "R7 skipped-to slot");
    look(19'h01015, "R7 superpage resident");

    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R1 missing responses actual=%0d expected=0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule